// File: doc/BRIEF.md
# Programmable Buffer Address Sequencer

This block produces one memory address for each request pulse. It holds a single pointer together with a buffer start, a buffer size, a signed stride and a control word. Four sequencing schemes are available. Linear sequencing adds the stride. Circular sequencing keeps the pointer inside a buffer of any size and folds it back at either end in hardware. Output bit reversal scrambles the low bits of the buffer offset on their way out. Reverse-carry stepping lets the pointer itself walk in FFT reorder sequence. The control word also chooses between two update orders. In the first, the address goes out before the pointer steps. In the second, the pointer steps first and the new value goes out.

A processor core or DMA engine first loads the five registers through a simple write port. It then pulses the request line once per operand access. The address appears on a registered output one clock after the request, together with a valid flag. All address arithmetic is modulo 2^16.

Top module: `agu_core`

## Requirements
- R1: After reset, all five registers hold zero and both `addr` and `addr_valid` are 0. `addr_valid` is 1 in exactly the cycle after a cycle with `req` high and is 0 otherwise. `addr` updates only after a request.
- R2: Linear sequencing applies when no mode bit is set. Each request advances the pointer by the stride, taken as a two's-complement 16-bit value, with wraparound modulo 2^16.
- R3: Circular sequencing applies when control bit 0 is set and the size is nonzero. The pointer offset from the start then stays in 0..size-1, for any size and for positive or negative strides whose magnitude is below the size. A step past either end folds back by the size.
- R4: With control bit 0 set and a size of zero, sequencing is linear as in R2.
- R5: With control bit 3 clear (post-step), the address emitted is the pointer before the update. With it set (pre-step), the address emitted is the pointer after the update.
- R6: Output bit reversal applies when control bit 1 is set. The pointer advances linearly. The emitted address is start + offset, where the low W bits of the offset are reversed and the bits above W are kept.
- R7: Reverse-carry stepping applies when control bit 2 is set. The low W bits of the offset are added to the low W bits of the stride, with carries running from bit W-1 down to bit 0. The offset bits above W are kept. The emitted address is the pointer itself. With the stride 2^(W-1), the offsets follow the bit-reversed count.
- R8: The width field is control bits 7:4 and encodes W-1, so W ranges from 1 to 16.
- R9: When several mode bits are set, reverse-carry (bit 2) wins over output reversal (bit 1), which wins over circular (bit 0).
- R10: The register write port uses `cfg_sel` values 0 start, 1 size, 2 pointer, 3 stride and 4 control. A write to the pointer in the same cycle as a request overrides that request's update. The address emitted for that request is still computed from the old register contents.
- R11: Without a request or a pointer write, the pointer holds its value. Writes with `cfg_sel` values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| req | input | 1 | Address request |
| addr | output | 16 | Generated address, registered |
| addr_valid | output | 1 | High one cycle after each request |

## Verification
A pointer write and a request can fall in the same clock edge. The write must win the pointer, while the emitted address still comes from the old state. The bench provokes this by raising `req` and a pointer write on the same falling edge. It then checks that the emitted address follows the old pointer and that the next request starts from the written value. Random runs also place writes to the start, size, stride and control registers directly before requests. The expected result for every request comes from a bench model that has its own reverse-carry and fold-back arithmetic.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [2:0] SEL_BASE = 3'd0;
  localparam logic [2:0] SEL_LEN  = 3'd1;
  localparam logic [2:0] SEL_PTR  = 3'd2;
  localparam logic [2:0] SEL_STEP = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam int CB_MOD = 0;
  localparam int CB_BRO = 1;
  localparam int CB_RCY = 2;
  localparam int CB_PRE = 3;
  localparam int CB_WID = 4;

  typedef enum logic [1:0] {MD_LIN, MD_MOD, MD_BRO, MD_RCY} agu_mode_t;
endpackage

// File: rtl/agu_regs.sv
module agu_regs
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int WFW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [2:0]     sel,
  input  logic [AW-1:0]  wdata,
  input  logic           upd_en,
  input  logic [AW-1:0]  upd_val,
  output logic [AW-1:0]  base,
  output logic [AW-1:0]  len,
  output logic [AW-1:0]  ptr,
  output logic [AW-1:0]  step,
  output logic           mod_en,
  output logic           bro_en,
  output logic           rcy_en,
  output logic           pre_en,
  output logic [WFW-1:0] wm1
);
  localparam int CW = CB_WID + WFW;

  logic [CW-1:0] ctrl;
  logic          ptr_wr;

  assign ptr_wr = we && (sel == SEL_PTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      len  <= '0;
      step <= '0;
      ctrl <= '0;
    end else if (we) begin
      case (sel)
        SEL_BASE: base <= wdata;
        SEL_LEN:  len  <= wdata;
        SEL_STEP: step <= wdata;
        SEL_CTRL: ctrl <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ptr_wr) ptr <= wdata;
    else if (upd_en) ptr <= upd_val;
  end

  assign mod_en = ctrl[CB_MOD];
  assign bro_en = ctrl[CB_BRO];
  assign rcy_en = ctrl[CB_RCY];
  assign pre_en = ctrl[CB_PRE];
  assign wm1    = ctrl[CW-1:CB_WID];

  // R10: a pointer write overrides any concurrent update
  assert_ptr_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (ptr == $past(wdata)));

  // R11: pointer holds without request or write
  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !ptr_wr) |=> $stable(ptr));
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW  = 16,
  parameter int WFW = 4
) (
  input  logic [AW-1:0]  x,
  input  logic [WFW-1:0] sh,
  output logic [AW-1:0]  y
);
  logic [AW-1:0] full;

  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign full[g] = x[AW-1-g];
  end

  assign y = full >> sh;
endmodule

// File: rtl/agu_step.sv
module agu_step
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int WFW = 4
) (
  input  agu_mode_t      mode,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  len,
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  step,
  input  logic [WFW-1:0] wm1,
  output logic [AW-1:0]  nxt,
  output logic [AW-1:0]  mask,
  output logic [WFW-1:0] sh
);
  localparam logic [WFW-1:0] TOPW = WFW'(AW - 1);

  logic [WFW-1:0]       wm1c;
  logic [AW-1:0]        off, lo_a, lo_b, ra, rb, rs, rc, off_rc;
  logic signed [AW+1:0] msum, madj, slen;
  logic [AW-1:0]        moff;

  assign wm1c = (wm1 > TOPW) ? TOPW : wm1;
  assign sh   = TOPW - wm1c;
  assign mask = {AW{1'b1}} >> sh;
  assign off  = ptr - base;

  // reverse-carry: reverse operands, add normally, reverse back
  assign lo_a = off & mask;
  assign lo_b = step & mask;

  agu_bitrev #(.AW(AW), .WFW(WFW)) u_rev_a (.x(lo_a), .sh(sh), .y(ra));
  agu_bitrev #(.AW(AW), .WFW(WFW)) u_rev_b (.x(lo_b), .sh(sh), .y(rb));
  assign rs = ra + rb;
  agu_bitrev #(.AW(AW), .WFW(WFW)) u_rev_s (.x(rs), .sh(sh), .y(rc));

  assign off_rc = (off & ~mask) | rc;

  // circular fold-back in either direction
  always_comb begin
    slen = $signed({2'b00, len});
    msum = $signed({2'b00, off}) + $signed({{2{step[AW-1]}}, step});
    if (msum < 0)          madj = msum + slen;
    else if (msum >= slen) madj = msum - slen;
    else                   madj = msum;
    moff = AW'(madj);
  end

  always_comb begin
    case (mode)
      MD_RCY:  nxt = base + off_rc;
      MD_MOD:  nxt = base + moff;
      default: nxt = ptr + step;
    endcase
  end
endmodule

// File: rtl/agu_map.sv
module agu_map #(
  parameter int AW  = 16,
  parameter int WFW = 4
) (
  input  logic           bro_on,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  ptr,
  input  logic [AW-1:0]  mask,
  input  logic [WFW-1:0] sh,
  output logic [AW-1:0]  addr
);
  logic [AW-1:0] off, off_lo, rev_lo;

  assign off    = ptr - base;
  assign off_lo = off & mask;

  agu_bitrev #(.AW(AW), .WFW(WFW)) u_rev (.x(off_lo), .sh(sh), .y(rev_lo));

  assign addr = bro_on ? (base + ((off & ~mask) | rev_lo)) : ptr;
endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req,
  output logic [AW-1:0] addr,
  output logic          addr_valid
);
  localparam int WFW = (AW > 1) ? $clog2(AW) : 1;

  logic [AW-1:0]  r_base, r_len, r_ptr, r_step;
  logic           r_mod, r_bro, r_rcy, r_pre;
  logic [WFW-1:0] r_wm1, sh;
  logic [AW-1:0]  ptr_nxt, mask, pick, mapped;
  agu_mode_t      mode;

  agu_regs #(.AW(AW), .WFW(WFW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .upd_en(req), .upd_val(ptr_nxt),
    .base(r_base), .len(r_len), .ptr(r_ptr), .step(r_step),
    .mod_en(r_mod), .bro_en(r_bro), .rcy_en(r_rcy), .pre_en(r_pre), .wm1(r_wm1)
  );

  always_comb begin
    if (r_rcy)                         mode = MD_RCY;
    else if (r_bro)                    mode = MD_BRO;
    else if (r_mod && (r_len != '0))   mode = MD_MOD;
    else                               mode = MD_LIN;
  end

  agu_step #(.AW(AW), .WFW(WFW)) u_step (
    .mode(mode), .base(r_base), .len(r_len), .ptr(r_ptr), .step(r_step),
    .wm1(r_wm1), .nxt(ptr_nxt), .mask(mask), .sh(sh)
  );

  assign pick = r_pre ? ptr_nxt : r_ptr;

  agu_map #(.AW(AW), .WFW(WFW)) u_map (
    .bro_on(mode == MD_BRO), .base(r_base), .ptr(pick), .mask(mask), .sh(sh),
    .addr(mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) addr <= mapped;
    end
  end

  logic          ptr_wr, plain;
  logic [AW-1:0] cur_off, step_mag;
  assign ptr_wr   = cfg_we && (cfg_sel == SEL_PTR);
  assign plain    = (mode == MD_LIN) || (mode == MD_MOD);
  assign cur_off  = r_ptr - r_base;
  assign step_mag = r_step[AW-1] ? (~r_step + 1'b1) : r_step;

  assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req |=> addr_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !req |=> !addr_valid);

  assert_post_step_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (req && plain && !r_pre) |=> (addr == $past(r_ptr)));
  assert_pre_step_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (req && plain && r_pre && !ptr_wr) |=> (addr == r_ptr));

  assert_mod_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (req && mode == MD_MOD && !cfg_we && cur_off < r_len && step_mag < r_len)
      |=> ((r_ptr - r_base) < r_len));

  assert_rcy_addr_is_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    (req && mode == MD_RCY && !ptr_wr)
      |=> (addr == ($past(r_pre) ? r_ptr : $past(r_ptr))));
endmodule

// File: tb/agu_core_bench.sv
`timescale 1ns/1ps
module agu_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        req = 1'b0;
  logic [15:0] addr;
  logic        addr_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_base, m_len, m_ptr, m_step, m_ctrl;

  agu_core #(.AW(16)) u_agu_core (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req(req), .addr(addr), .addr_valid(addr_valid)
  );

  always #10 clk = ~clk;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  function automatic logic [15:0] f_rev(input logic [15:0] x, input int w);
    logic [15:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = x[w-1-i];
    return r;
  endfunction

  function automatic logic [15:0] f_rcadd(input logic [15:0] a,
                                          input logic [15:0] b, input int w);
    logic [15:0] r = '0;
    int c = 0;
    for (int i = w - 1; i >= 0; i--) begin
      int t;
      t = int'(a[i]) + int'(b[i]) + c;
      r[i] = t[0];
      c = t >> 1;
    end
    return r;
  endfunction

  task automatic model_req(output logic [15:0] e);
    logic [15:0] off, nxt, pick, msk;
    int w, s;
    w = int'(m_ctrl[7:4]) + 1;
    msk = (w == 16) ? 16'hFFFF : 16'((32'd1 << w) - 1);
    if (m_ctrl[2]) begin
      off = m_ptr - m_base;
      nxt = m_base + ((off & ~msk) | f_rcadd(off & msk, m_step & msk, w));
    end else if (m_ctrl[1]) begin
      nxt = m_ptr + m_step;
    end else if (m_ctrl[0] && m_len != 0) begin
      off = m_ptr - m_base;
      s = int'(off) + int'($signed(m_step));
      if (s < 0) s += int'(m_len);
      else if (s >= int'(m_len)) s -= int'(m_len);
      nxt = m_base + 16'(s);
    end else begin
      nxt = m_ptr + m_step;
    end
    pick = m_ctrl[3] ? nxt : m_ptr;
    if (!m_ctrl[2] && m_ctrl[1]) begin
      off = pick - m_base;
      e = m_base + ((off & ~msk) | f_rev(off & msk, w));
    end else begin
      e = pick;
    end
    m_ptr = nxt;
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_base = d;
      3'd1: m_len  = d;
      3'd2: m_ptr  = d;
      3'd3: m_step = d;
      3'd4: m_ctrl = {8'd0, d[7:0]};
      default: ;
    endcase
  endtask

  task automatic setup(input logic [15:0] b, input logic [15:0] l,
                       input logic [15:0] p, input logic [15:0] st,
                       input logic [15:0] c);
    cfg(3'd0, b); cfg(3'd1, l); cfg(3'd2, p); cfg(3'd3, st); cfg(3'd4, c);
  endtask

  task automatic issue(input string rq, input bit has_lit = 1'b0,
                       input logic [15:0] lit = 16'd0);
    logic [15:0] e;
    @(negedge clk);
    req = 1'b1;
    model_req(e);
    @(negedge clk);
    req = 1'b0;
    chk(rq, "valid", {31'd0, addr_valid}, 32'd1);
    chk(rq, "addr", {16'd0, addr}, {16'd0, e});
    if (has_lit) chk(rq, "addr literal", {16'd0, addr}, {16'd0, lit});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_base = 0; m_len = 0; m_ptr = 0; m_step = 0; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset valid", {31'd0, addr_valid}, 32'd0);
    chk("R1", "reset addr", {16'd0, addr}, 32'd0);
    issue("R1", 1'b1, 16'h0000);
    @(negedge clk);
    chk("R1", "idle valid", {31'd0, addr_valid}, 32'd0);

    // R2 linear post-step, negative stride wraps modulo 2^16
    setup(16'd0, 16'd0, 16'd100, 16'd3, 16'h0000);
    issue("R2", 1'b1, 16'd100);
    issue("R2", 1'b1, 16'd103);
    setup(16'd0, 16'd0, 16'd1, 16'hFFFE, 16'h0000);
    issue("R2", 1'b1, 16'd1);
    issue("R2", 1'b1, 16'hFFFF);

    // R5 pre-step
    setup(16'd0, 16'd0, 16'd100, 16'd3, 16'h0008);
    issue("R5", 1'b1, 16'd103);
    issue("R5", 1'b1, 16'd106);

    // R3 circular, size 5, both directions
    setup(16'd10, 16'd5, 16'd10, 16'd2, 16'h0001);
    issue("R3", 1'b1, 16'd10); issue("R3", 1'b1, 16'd12);
    issue("R3", 1'b1, 16'd14); issue("R3", 1'b1, 16'd11);
    issue("R3", 1'b1, 16'd13); issue("R3", 1'b1, 16'd10);
    setup(16'd10, 16'd5, 16'd10, 16'hFFFE, 16'h0001);
    issue("R3", 1'b1, 16'd10); issue("R3", 1'b1, 16'd13);
    issue("R3", 1'b1, 16'd11); issue("R3", 1'b1, 16'd14);
    issue("R3", 1'b1, 16'd12);

    // R4 size zero disables wrap
    setup(16'd10, 16'd0, 16'd10, 16'd2, 16'h0001);
    issue("R4", 1'b1, 16'd10); issue("R4", 1'b1, 16'd12);
    issue("R4", 1'b1, 16'd14); issue("R4", 1'b1, 16'd16);

    // R6 / R8 output reversal, W=3
    setup(16'h0040, 16'd0, 16'h0040, 16'd1, 16'h0022);
    issue("R6", 1'b1, 16'h0040); issue("R6", 1'b1, 16'h0044);
    issue("R6", 1'b1, 16'h0042); issue("R6", 1'b1, 16'h0046);
    issue("R6", 1'b1, 16'h0041); issue("R6", 1'b1, 16'h0045);
    issue("R6", 1'b1, 16'h0043); issue("R6", 1'b1, 16'h0047);
    issue("R6", 1'b1, 16'h0048);
    // R8 full width W=16
    setup(16'd0, 16'd0, 16'd1, 16'd1, 16'h00F2);
    issue("R8", 1'b1, 16'h8000); issue("R8", 1'b1, 16'h4000);

    // R7 reverse-carry, W=3, stride 4
    setup(16'h0080, 16'd0, 16'h0080, 16'd4, 16'h0024);
    issue("R7", 1'b1, 16'h0080); issue("R7", 1'b1, 16'h0084);
    issue("R7", 1'b1, 16'h0082); issue("R7", 1'b1, 16'h0086);
    issue("R7", 1'b1, 16'h0081); issue("R7", 1'b1, 16'h0085);
    issue("R7", 1'b1, 16'h0083); issue("R7", 1'b1, 16'h0087);
    issue("R7", 1'b1, 16'h0080);
    setup(16'h0080, 16'd0, 16'h0080, 16'd4, 16'h002C);
    issue("R7", 1'b1, 16'h0084);

    // R9 priority
    setup(16'h0080, 16'd3, 16'h0080, 16'd4, 16'h0027);
    issue("R9", 1'b1, 16'h0080); issue("R9", 1'b1, 16'h0084);
    issue("R9", 1'b1, 16'h0082);
    setup(16'd0, 16'd3, 16'd0, 16'd1, 16'h0013);
    issue("R9", 1'b1, 16'h0000); issue("R9", 1'b1, 16'h0002);
    issue("R9", 1'b1, 16'h0001); issue("R9", 1'b1, 16'h0003);
    issue("R9", 1'b1, 16'h0004);

    // R10 pointer write together with a request
    setup(16'd0, 16'd0, 16'h0300, 16'd1, 16'h0000);
    begin
      logic [15:0] e;
      @(negedge clk);
      req = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 16'h0200;
      model_req(e);
      m_ptr = 16'h0200;
      @(negedge clk);
      req = 1'b0; cfg_we = 1'b0;
      chk("R10", "addr old state", {16'd0, addr}, 32'h0300);
    end
    issue("R10", 1'b1, 16'h0200);

    // R11 unused selects and idle cycles change nothing
    cfg(3'd6, 16'hFFFF);
    cfg(3'd5, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R11", "addr held", {16'd0, addr}, 32'h0200);
    issue("R11", 1'b1, 16'h0201);

    // random configurations
    for (int it = 0; it < 250; it++) begin
      logic [15:0] b, l, st, c, mag;
      b = 16'($urandom);
      l = 16'(1 + $urandom % 40);
      mag = 16'($urandom % l);
      st = ($urandom % 2) ? (~mag + 16'd1) : mag;
      c = {8'd0, 4'($urandom % 16), 4'($urandom % 16)};
      setup(b, l, b + 16'($urandom % l), st, c);
      if ((it % 7) == 0) cfg(3'd7, 16'($urandom));
      for (int k = 0; k < 4; k++) begin
        if (c[2]) issue("R7");
        else if (c[1]) issue("R6");
        else if (c[0]) issue("R3");
        else issue("R2");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule